// File: doc/BRIEF.md
# Nonvolatile Store and Recall Sequencer

This block controls a memory built from a volatile array with a nonvolatile shadow array behind it. It decides when the whole array is copied to the shadow side (a store) and when the shadow is copied back (a recall). While either transfer runs, it withholds the read and write grants that the access port would otherwise give.

A store can start in three ways. The supply comparator can report a falling supply. An external agent can pull the shared open-drain busy line low. Software can raise a one-cycle request. The first two only take effect if the array has been written since the last completed transfer. A line request first opens a grace window: reads go on during the window, and a write already under way may finish. At power-up a recall stays pending until the supply comparator reports a good supply. The recall then runs for a fixed number of cycles.

The transfers themselves are modelled by cycle counters. Their start and done pulses are brought out so that the cycle timing can be observed.

Top module: `nvx_xfer_seq`

## Requirements
- R1: In the idle state a read grant is given exactly when chip enable (active low) and output enable (active low) are low, write enable (active low) is high, and the sampled busy line is high.
- R2: In the idle state a write grant is given exactly when chip enable and write enable are both low and the busy line is high.
- R3: No read or write grant is given during a store, during a recall, or while a power-up recall is pending.
- R4: A store drives the busy line low (busy_oe high) for exactly STORE_CYC consecutive cycles. store_start pulses in the first of those cycles and store_done pulses in the last.
- R5: A falling edge of the busy line that another agent causes opens a grace window of HOLD_CYC cycles. Reads are granted during the window even though the line is low.
- R6: A write granted in the cycle of the falling edge may continue through the grace window. A write that starts after the edge is not granted, during the window or afterwards, until the busy line is high again.
- R7: A store requested by the busy line starts in the cycle after the grace window ends, and only if the array is dirty. Otherwise no store occurs.
- R8: A software store request starts a store in the next cycle, whether or not the array is dirty.
- R9: After reset a recall is pending and all access is blocked. When the supply is above the threshold and not below it, a recall runs for RECALL_CYC cycles (recall_start in the first, recall_done in the last). Grants resume in the cycle after.
- R10: When the supply-below flag rises while the block is idle, it starts a store if the array is dirty. After that, or at once if the array is clean, a recall is pending and access stays blocked.
- R11: A completed store or recall clears the dirty flag. Only a granted write sets it.
- R12: The block's own drive of the busy line is never taken as an external request. When a store ends, the block returns to idle with no grace window and no further store.
- R13: When triggers arrive in the same cycle, a supply-fall store wins over a line request, and a line request wins over a software request.
- R14: A request that arrives while a transfer is running is dropped, not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable (synchronous view), active low |
| oe_n | input | 1 | Output enable (synchronous view), active low |
| we_n | input | 1 | Write enable (synchronous view), active low |
| busy_i | input | 1 | Sampled level of the shared open-drain busy/request line |
| busy_oe | output | 1 | Pulls the busy line low while a store runs |
| sw_store_req | input | 1 | One-cycle software store request |
| pwr_below | input | 1 | Supply comparator: supply below the switch threshold |
| pwr_above | input | 1 | Supply comparator: supply above the switch threshold |
| rd_grant | output | 1 | Read enable to the array |
| wr_grant | output | 1 | Write enable to the array |
| store_start | output | 1 | Pulse in the first store cycle |
| store_done | output | 1 | Pulse in the last store cycle |
| recall_start | output | 1 | Pulse in the first recall cycle |
| recall_done | output | 1 | Pulse in the last recall cycle |

## Verification
The bench targets the following corner cases:
- **Grant truth table.** It sweeps every enable combination against the grant rules. A mistake there shows up as a read granted together with a write, or a write granted while the line is low.
- **Grace window.** It times the window and the store that follows, cycle by cycle. An off-by-one counter would move store_start away from cycle HOLD_CYC+1.
- **Write that spans the falling edge.** It checks that the in-flight write keeps its grant and that a new write is refused. A design without the carry would cut the in-flight write short, and a loose one would let the new write through.
- **Skipped stores, priority and dropped requests.** It runs clean line stores and clean supply-fall stores, simultaneous triggers, and requests made during a store. A wrong dirty flag would produce a spurious store. A wrong priority would move the store start. A queued request would produce a second store.

// File: rtl/nvx_pkg.sv
package nvx_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP  = 3'd0,
    ST_RECALL = 3'd1,
    ST_IDLE   = 3'd2,
    ST_HOLD   = 3'd3,
    ST_STORE  = 3'd4
  } nvx_state_e;

  typedef enum logic [1:0] {
    TRG_NONE  = 2'd0,
    TRG_POWER = 2'd1,
    TRG_HW    = 2'd2,
    TRG_SW    = 2'd3
  } nvx_trig_e;

  // Priority: supply fall, then line request, then software request.
  function automatic nvx_trig_e pick_trigger(input logic pwr, input logic hw, input logic sw);
    if (pwr)     return TRG_POWER;
    else if (hw) return TRG_HW;
    else if (sw) return TRG_SW;
    else         return TRG_NONE;
  endfunction

  function automatic logic read_cycle(input logic ce_n, input logic oe_n,
                                      input logic we_n, input logic line_hi);
    return !ce_n && !oe_n && we_n && line_hi;
  endfunction

  function automatic logic write_cycle(input logic ce_n, input logic we_n);
    return !ce_n && !we_n;
  endfunction

  // Bits needed to count 0 .. max-1 for the longest of three durations.
  function automatic int cnt_bits(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

endpackage

// File: rtl/nvx_trigger_detect.sv
module nvx_trigger_detect
  import nvx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      busy_i,
  input  logic      busy_oe,
  input  logic      pwr_below,
  input  logic      sw_req,
  output logic      hw_fall,
  output logic      pwr_fall,
  output nvx_trig_e trig
);
  logic busy_prev;
  logic pwr_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_prev <= 1'b1;
      pwr_prev  <= 1'b1;
    end else begin
      busy_prev <= busy_i;
      pwr_prev  <= pwr_below;
    end
  end

  // A fall counts as a request only when this block is not driving the line.
  assign hw_fall  = busy_prev && !busy_i && !busy_oe;
  assign pwr_fall = pwr_below && !pwr_prev;
  assign trig     = pick_trigger(pwr_below, hw_fall, sw_req);

  AST_OWN_DRIVE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_oe) |-> !hw_fall);  // R12
endmodule

// File: rtl/nvx_access_gate.sv
module nvx_access_gate
  import nvx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       we_n,
  input  logic       busy_i,
  input  nvx_state_e mode,
  output logic       rd_grant,
  output logic       wr_grant
);
  logic wr_q;
  logic wr_act;
  logic wr_cont;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b0;
    else        wr_q <= wr_grant;
  end

  assign wr_act  = write_cycle(ce_n, we_n);
  assign wr_cont = wr_act && wr_q;

  always_comb begin
    rd_grant = 1'b0;
    wr_grant = 1'b0;
    case (mode)
      ST_IDLE: begin
        rd_grant = read_cycle(ce_n, oe_n, we_n, busy_i);
        wr_grant = wr_act && (busy_i || wr_cont);
      end
      ST_HOLD: begin
        rd_grant = read_cycle(ce_n, oe_n, we_n, 1'b1);
        wr_grant = wr_cont;
      end
      default: begin
        rd_grant = 1'b0;
        wr_grant = 1'b0;
      end
    endcase
  end

  AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_grant && wr_grant));  // R1
  AST_HOLD_NO_NEW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ST_HOLD && wr_grant) |-> $past(wr_grant));  // R6
endmodule

// File: rtl/nvx_xfer_timer.sv
module nvx_xfer_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/nvx_xfer_seq.sv
module nvx_xfer_seq
  import nvx_pkg::*;
#(
  parameter int STORE_CYC  = 16,
  parameter int RECALL_CYC = 12,
  parameter int HOLD_CYC   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic busy_i,
  output logic busy_oe,
  input  logic sw_store_req,
  input  logic pwr_below,
  input  logic pwr_above,
  output logic rd_grant,
  output logic wr_grant,
  output logic store_start,
  output logic store_done,
  output logic recall_start,
  output logic recall_done
);
  localparam int CW = cnt_bits(STORE_CYC, RECALL_CYC, HOLD_CYC);
  localparam logic [CW-1:0] STORE_LAST  = CW'(STORE_CYC - 1);
  localparam logic [CW-1:0] RECALL_LAST = CW'(RECALL_CYC - 1);
  localparam logic [CW-1:0] HOLD_LAST   = CW'(HOLD_CYC - 1);

  nvx_state_e    state_q, state_d;
  nvx_trig_e     trig;
  logic [CW-1:0] cnt;
  logic          restart;
  logic          dirty_q;
  logic          hw_fall;
  logic          pwr_fall;
  logic          store_last, recall_last, hold_last;
  logic          pwr_ok;

  nvx_trigger_detect u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_i   (busy_i),
    .busy_oe  (busy_oe),
    .pwr_below(pwr_below),
    .sw_req   (sw_store_req),
    .hw_fall  (hw_fall),
    .pwr_fall (pwr_fall),
    .trig     (trig)
  );

  nvx_access_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .we_n    (we_n),
    .busy_i  (busy_i),
    .mode    (state_q),
    .rd_grant(rd_grant),
    .wr_grant(wr_grant)
  );

  nvx_xfer_timer #(.W(CW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(restart),
    .cnt    (cnt)
  );

  assign pwr_ok      = pwr_above && !pwr_below;
  assign store_last  = (state_q == ST_STORE)  && (cnt == STORE_LAST);
  assign recall_last = (state_q == ST_RECALL) && (cnt == RECALL_LAST);
  assign hold_last   = (state_q == ST_HOLD)   && (cnt == HOLD_LAST);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_PWRUP:  if (pwr_ok) state_d = ST_RECALL;
      ST_RECALL: if (recall_last) state_d = ST_IDLE;
      ST_IDLE: begin
        case (trig)
          TRG_POWER: state_d = dirty_q ? ST_STORE : ST_PWRUP;
          TRG_HW:    state_d = ST_HOLD;
          TRG_SW:    state_d = ST_STORE;
          default:   state_d = ST_IDLE;
        endcase
      end
      ST_HOLD: begin
        if (pwr_below)      state_d = dirty_q ? ST_STORE : ST_PWRUP;
        else if (hold_last) state_d = dirty_q ? ST_STORE : ST_IDLE;
      end
      ST_STORE:  if (store_last) state_d = pwr_below ? ST_PWRUP : ST_IDLE;
      default:   state_d = ST_PWRUP;
    endcase
  end

  assign restart = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_PWRUP;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         dirty_q <= 1'b0;
    else if (store_last || recall_last) dirty_q <= 1'b0;
    else if (wr_grant)                  dirty_q <= 1'b1;
  end

  assign busy_oe      = (state_q == ST_STORE);
  assign store_start  = (state_q == ST_STORE)  && (cnt == '0);
  assign recall_start = (state_q == ST_RECALL) && (cnt == '0);
  assign store_done   = store_last;
  assign recall_done  = recall_last;

  AST_NO_GRANT_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_oe || state_q == ST_RECALL || state_q == ST_PWRUP) |-> (!rd_grant && !wr_grant));  // R3
  AST_BUSY_RISE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_oe) |-> store_start);  // R4
  AST_DONE_CLEARS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (store_done || recall_done) |=> !dirty_q);  // R11
  AST_CLEAN_HOLD_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_last && !dirty_q && !pwr_below) |=> !busy_oe);  // R7
  AST_IDLE_READ_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && rd_grant) |-> busy_i);  // R1
  AST_STORE_RECALL_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_start && recall_start));  // R4
  AST_SUPPLY_FALL_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && pwr_fall) |=> (state_q != ST_IDLE));  // R10
endmodule

// File: tb/nvx_xfer_seq_test.sv
module nvx_xfer_seq_test;
  localparam int S = 6;
  localparam int R = 5;
  localparam int D = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic ext_pull = 1'b0;
  logic sw_req = 1'b0;
  logic pwr_below = 1'b1, pwr_above = 1'b0;
  logic busy_oe, busy_line;
  logic rd_grant, wr_grant, store_start, store_done, recall_start, recall_done;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  assign busy_line = !(busy_oe || ext_pull);

  nvx_xfer_seq #(.STORE_CYC(S), .RECALL_CYC(R), .HOLD_CYC(D)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .busy_i(busy_line), .busy_oe(busy_oe), .sw_store_req(sw_req),
    .pwr_below(pwr_below), .pwr_above(pwr_above),
    .rd_grant(rd_grant), .wr_grant(wr_grant),
    .store_start(store_start), .store_done(store_done),
    .recall_start(recall_start), .recall_done(recall_done)
  );

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #5;
  endtask

  task automatic do_write();
    oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    cyc();
    ce_n = 1'b1; we_n = 1'b1;
    cyc();
  endtask

  task automatic do_recall(input string req);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    pwr_below = 1'b0; pwr_above = 1'b1;
    for (int k = 1; k <= R + 1; k++) begin
      cyc();
      chk(rd_grant, logic'(k == R + 1), req, "read grant around recall");
      chk(recall_start, logic'(k == 1), req, "recall_start");
      chk(recall_done, logic'(k == R), req, "recall_done");
    end
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    repeat (3) cyc();
    rst_n = 1'b1;
    // R9: pending recall blocks access while the supply is low
    for (int k = 0; k < 4; k++) begin
      cyc();
      chk(rd_grant, 1'b0, "R9", "read while supply low");
      chk(recall_start, 1'b0, "R9", "no recall while supply low");
      chk(busy_oe, 1'b0, "R3", "no busy drive at reset");
    end
    do_recall("R9");

    // R1 R2: full enable sweep in idle
    for (int i = 0; i < 8; i++) begin
      ce_n = i[0]; oe_n = i[1]; we_n = i[2];
      #1;
      chk(rd_grant, logic'(!i[0] && !i[1] && i[2]), "R1", "read grant sweep");
      chk(wr_grant, logic'(!i[0] && !i[2]), "R2", "write grant sweep");
      cyc();
    end

    // R5 R7 R4: dirty line request, grace window then store
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    ext_pull = 1'b1;
    for (int k = 1; k <= D + S + 1; k++) begin
      cyc();
      chk(rd_grant, logic'(k <= D), "R5", "read in grace window");
      chk(busy_oe, logic'(k > D && k <= D + S), "R4", "busy drive span");
      chk(store_start, logic'(k == D + 1), "R7", "store after window");
      chk(store_done, logic'(k == D + S), "R4", "store_done");
    end
    ext_pull = 1'b0;
    #1;
    chk(rd_grant, 1'b1, "R1", "read after line released");
    ce_n = 1'b1; oe_n = 1'b1;
    cyc();

    // R7 R11: clean line request performs no store
    ext_pull = 1'b1;
    n = 0;
    for (int k = 0; k < D + S + 2; k++) begin
      cyc();
      if (store_start || busy_oe) n++;
    end
    chk(logic'(n == 0), 1'b1, "R11", "clean line request skipped");
    ce_n = 1'b0; we_n = 1'b0;
    #1;
    chk(wr_grant, 1'b0, "R6", "write while line held low");
    ext_pull = 1'b0;
    #1;
    chk(wr_grant, 1'b1, "R2", "write after line high");
    cyc();

    // R6: write in flight across the falling edge
    ext_pull = 1'b1;
    #1;
    chk(wr_grant, 1'b1, "R6", "in-flight write at edge");
    cyc();
    chk(wr_grant, 1'b1, "R6", "in-flight write in window");
    we_n = 1'b1;
    #1;
    chk(wr_grant, 1'b0, "R6", "write ended");
    cyc();
    we_n = 1'b0;
    #1;
    chk(wr_grant, 1'b0, "R6", "new write blocked in window");
    we_n = 1'b1; ce_n = 1'b1;
    n = 0;
    for (int k = 0; k < D + S + 2; k++) begin
      cyc();
      if (store_start) n++;
    end
    chk(logic'(n == 1), 1'b1, "R7", "dirty line request stores once");
    ext_pull = 1'b0;
    cyc();

    // R8 R14 R12 R3: clean software store, second request dropped
    ce_n = 1'b0; oe_n = 1'b0;
    sw_req = 1'b1;
    for (int k = 1; k <= S + 1; k++) begin
      cyc();
      sw_req = (k == 2);
      chk(busy_oe, logic'(k <= S), "R8", "software store busy span");
      chk(store_start, logic'(k == 1), "R8", "software store start");
      chk(store_done, logic'(k == S), "R8", "software store done");
      chk(rd_grant, logic'(k == S + 1), "R3", "read blocked during store");
    end
    sw_req = 1'b0;
    chk(rd_grant, 1'b1, "R12", "idle right after own store");
    n = 0;
    for (int k = 0; k < D + S + 2; k++) begin
      cyc();
      if (store_start || busy_oe) n++;
    end
    chk(logic'(n == 0), 1'b1, "R14", "request in store dropped");
    ce_n = 1'b1; oe_n = 1'b1;

    // R13: line request beats software request
    do_write();
    ext_pull = 1'b1; sw_req = 1'b1;
    for (int k = 1; k <= D + S + 1; k++) begin
      cyc();
      sw_req = 1'b0;
      chk(store_start, logic'(k == D + 1), "R13", "line beats software");
    end
    ext_pull = 1'b0;
    cyc();

    // R10: supply fall with dirty array
    do_write();
    ce_n = 1'b0; oe_n = 1'b0;
    pwr_below = 1'b1; pwr_above = 1'b0;
    for (int k = 1; k <= S + 3; k++) begin
      cyc();
      chk(busy_oe, logic'(k <= S), "R10", "power store busy");
      chk(store_start, logic'(k == 1), "R10", "power store start");
      chk(rd_grant, 1'b0, "R10", "access blocked after supply fall");
    end
    do_recall("R10");

    // R10 R11: supply fall with clean array, no store
    ce_n = 1'b0; oe_n = 1'b0;
    pwr_below = 1'b1; pwr_above = 1'b0;
    for (int k = 0; k < 6; k++) begin
      cyc();
      chk(busy_oe, 1'b0, "R11", "clean supply fall no store");
      chk(rd_grant, 1'b0, "R10", "blocked pending recall");
    end
    do_recall("R9");

    // R13: supply fall beats line and software
    do_write();
    pwr_below = 1'b1; pwr_above = 1'b0; ext_pull = 1'b1; sw_req = 1'b1;
    ce_n = 1'b0; oe_n = 1'b0;
    for (int k = 1; k <= S + 2; k++) begin
      cyc();
      sw_req = 1'b0;
      chk(store_start, logic'(k == 1), "R13", "supply fall first");
    end
    ext_pull = 1'b0;
    #1;
    chk(rd_grant, 1'b0, "R13", "still awaiting recall");
    do_recall("R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule